// File: doc/BRIEF.md
# Read Strobe Window Centering Trainer

This block picks the capture delay for read data on a memory data byte. When it is started, it steps an input delay tap from the lowest setting to the highest. At each setting it asks the memory side for one read of a training pattern that was already stored there, and it compares the returned word with the expected pattern. Each tap then counts as passing or failing, and the block keeps a record of the longest unbroken run of passing taps.

When the sweep ends, the block reports the first and last tap of the widest passing window and the tap at its midpoint, which leaves the most margin on both sides. It then drives that midpoint onto the tap-select output. If the window is narrower than a programmable minimum, the block flags a failure. In per-bit mode the same sweep also tracks a separate window for every data line, because the pattern toggles all lines at once, and the block reports a deskew tap and a failure flag for each bit.

The memory model and the delay elements sit outside the block. It talks to them through a request/acknowledge read handshake and the tap-select output.

Top module: `read_window_trainer`

## Requirements
- R1: While reset is high and after it, until the first start, `busy`, `done`, `rd_req`, `fail` and `tap_sel` are all 0.
- R2: A sweep issues exactly one read per tap, in ascending order from 0 to 2^TAP_W-1. `tap_sel` shows the tap under test and stays stable while `rd_req` is high and not yet acknowledged.
- R3: A tap passes for the whole word only when every bit of `rd_data` equals the matching bit of `pattern`.
- R4: The reported window is the longest run of consecutive passing taps. When two runs have the same length, the one at the lower taps is reported.
- R5: `win_center` equals (`win_start` + `win_end`) >> 1, rounded down.
- R6: `fail` is 1 when the window length is less than `min_width`, which is latched at start. A window exactly `min_width` long passes. If no tap passes, `win_start` and `win_end` are both 0 and `fail` is 1.
- R7: When `per_bit_mode` is 1 at start, slice b of `bit_tap` (bits b*TAP_W upward) holds the midpoint of bit b's own longest passing window, and `bit_fail[b]` applies the R6 rule to that window. All bits come from the same single sweep.
- R8: When `per_bit_mode` is 0 at start, every `bit_tap` slice equals `win_center` and every `bit_fail` bit equals `fail`.
- R9: While `done` is high, `tap_sel` drives `win_center`. `done` stays high until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a sweep (accepted when idle or done) |
| per_bit_mode | input | 1 | Report independent per-bit windows |
| min_width | input | TAP_W+1 | Smallest acceptable window length |
| pattern | input | DATA_W | Expected training word |
| rd_req | output | 1 | Read request for the current tap |
| rd_ack | input | 1 | One-cycle acknowledge carrying `rd_data` |
| rd_data | input | DATA_W | Returned word |
| tap_sel | output | TAP_W | Delay tap: sweep tap while busy, trained center otherwise |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Results valid |
| fail | output | 1 | Word window narrower than minimum |
| win_start | output | TAP_W | First tap of the word window |
| win_end | output | TAP_W | Last tap of the word window |
| win_center | output | TAP_W | Midpoint of the word window |
| bit_tap | output | DATA_W*TAP_W | Per-bit deskew taps |
| bit_fail | output | DATA_W | Per-bit window failure flags |

## Verification
The hardest situation to reach from the ports is a sweep in which every data line has a different passing window, so that the per-bit results and the word result all differ in one sweep. The bench memory model holds a pass map per bit and per tap, and it flips each returned bit according to that map at the tap shown on `tap_sel`. With staggered maps, the word window becomes the narrow overlap of all the bit windows. A second per-bit run blanks one line entirely, which makes that bit and the word fail while the other bits still pass. Table rows cover equal-length runs, windows touching either end of the range, a window exactly at the minimum width and an all-fail sweep.

// File: rtl/rwt_pkg.sv
package rwt_pkg;

    typedef enum logic [2:0] {
        SW_IDLE = 3'd0,
        SW_REQ  = 3'd1,
        SW_GAP  = 3'd2,
        SW_FIN  = 3'd3,
        SW_DONE = 3'd4
    } sweep_state_e;

    // Midpoint of a closed tap interval, rounded down.
    function automatic int unsigned mid_tap(input int unsigned lo, input int unsigned hi);
        return (lo + hi) >> 1;
    endfunction

    // Last tap of a run given its first tap and length (0 when empty).
    function automatic int unsigned run_last(input int unsigned first, input int unsigned len);
        return (len == 0) ? 0 : first + len - 1;
    endfunction

endpackage

// File: rtl/rwt_run_tracker.sv
module rwt_run_tracker #(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             sample_en,
    input  logic             pass,
    input  logic [TAP_W-1:0] tap,
    output logic [TAP_W-1:0] best_start,
    output logic [TAP_W:0]   best_len
);
    localparam int LEN_W = TAP_W + 1;
    localparam int DEPTH = 1 << TAP_W;

    logic [TAP_W-1:0] cur_start_q;
    logic [LEN_W-1:0] cur_len_q;
    logic [TAP_W-1:0] best_start_q;
    logic [LEN_W-1:0] best_len_q;
    logic [TAP_W-1:0] run_first;
    logic [LEN_W-1:0] run_len;

    always_comb begin
        run_first = (cur_len_q == '0) ? tap : cur_start_q;
        run_len   = cur_len_q + LEN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cur_start_q  <= '0;
            cur_len_q    <= '0;
            best_start_q <= '0;
            best_len_q   <= '0;
        end else if (sample_en) begin
            if (pass) begin
                cur_start_q <= run_first;
                cur_len_q   <= run_len;
                // strict compare keeps the earlier run on a tie
                if (run_len > best_len_q) begin
                    best_start_q <= run_first;
                    best_len_q   <= run_len;
                end
            end else begin
                cur_len_q <= '0;
            end
        end
    end

    assign best_start = best_start_q;
    assign best_len   = best_len_q;

    // R4: the recorded best run never shrinks within a sweep
    a_r4_best_grows: assert property (@(posedge clk) disable iff (rst)
        !clear |=> (best_len_q >= $past(best_len_q)));

    // R4: a run cannot be longer than the tap range
    a_r4_len_bound: assert property (@(posedge clk) disable iff (rst)
        (best_len_q <= LEN_W'(DEPTH)) && (cur_len_q <= LEN_W'(DEPTH)));

endmodule

// File: rtl/rwt_window_eval.sv
module rwt_window_eval #(
    parameter int TAP_W = 5
) (
    input  logic [TAP_W-1:0] best_start,
    input  logic [TAP_W:0]   best_len,
    input  logic [TAP_W:0]   min_width,
    output logic [TAP_W-1:0] w_start,
    output logic [TAP_W-1:0] w_end,
    output logic [TAP_W-1:0] w_center,
    output logic             w_fail
);
    import rwt_pkg::*;

    logic [TAP_W-1:0] first_tap;
    logic [TAP_W-1:0] last_tap;

    always_comb begin
        first_tap = (best_len == '0) ? '0 : best_start;
        last_tap  = TAP_W'(run_last(int'(best_start), int'(best_len)));
        w_start   = first_tap;
        w_end     = last_tap;
        w_center  = TAP_W'(mid_tap(int'(first_tap), int'(last_tap)));
        w_fail    = (best_len == '0) || (best_len < min_width);
    end

endmodule

// File: rtl/rwt_sweep_ctrl.sv
module rwt_sweep_ctrl #(
    parameter int TAP_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             rd_ack,
    output logic             rd_req,
    output logic [TAP_W-1:0] tap,
    output logic             clear,
    output logic             sample_en,
    output logic             fin,
    output logic             busy,
    output logic             done
);
    import rwt_pkg::*;

    localparam logic [TAP_W-1:0] TAP_MAX = '1;

    sweep_state_e     state_q;
    logic [TAP_W-1:0] tap_q;
    logic             can_start;

    assign can_start = (state_q == SW_IDLE) || (state_q == SW_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SW_IDLE;
            tap_q   <= '0;
        end else begin
            case (state_q)
                SW_IDLE, SW_DONE: begin
                    if (start) begin
                        state_q <= SW_REQ;
                        tap_q   <= '0;
                    end
                end
                SW_REQ: begin
                    if (rd_ack) begin
                        if (tap_q == TAP_MAX) begin
                            state_q <= SW_FIN;
                        end else begin
                            tap_q   <= tap_q + TAP_W'(1);
                            state_q <= SW_GAP;
                        end
                    end
                end
                SW_GAP:  state_q <= SW_REQ;
                SW_FIN:  state_q <= SW_DONE;
                default: state_q <= SW_IDLE;
            endcase
        end
    end

    assign rd_req    = (state_q == SW_REQ);
    assign tap       = tap_q;
    assign clear     = start && can_start;
    assign sample_en = (state_q == SW_REQ) && rd_ack;
    assign fin       = (state_q == SW_FIN);
    assign busy      = (state_q == SW_REQ) || (state_q == SW_GAP) || (state_q == SW_FIN);
    assign done      = (state_q == SW_DONE);

    // R2: a pending request keeps the same tap until acknowledged
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(tap_q)));

    // R2: the sweep only finishes after the top tap was read
    a_r2_last_tap: assert property (@(posedge clk) disable iff (rst)
        fin |-> (tap_q == TAP_MAX));

endmodule

// File: rtl/read_window_trainer.sv
module read_window_trainer #(
    parameter int DATA_W    = 8,
    parameter int TAP_W     = 5,
    parameter bit PER_BIT_EN = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    start,
    input  logic                    per_bit_mode,
    input  logic [TAP_W:0]          min_width,
    input  logic [DATA_W-1:0]       pattern,
    output logic                    rd_req,
    input  logic                    rd_ack,
    input  logic [DATA_W-1:0]       rd_data,
    output logic [TAP_W-1:0]        tap_sel,
    output logic                    busy,
    output logic                    done,
    output logic                    fail,
    output logic [TAP_W-1:0]        win_start,
    output logic [TAP_W-1:0]        win_end,
    output logic [TAP_W-1:0]        win_center,
    output logic [DATA_W*TAP_W-1:0] bit_tap,
    output logic [DATA_W-1:0]       bit_fail
);
    localparam int LEN_W = TAP_W + 1;

    logic             clear, sample_en, fin;
    logic [TAP_W-1:0] sweep_tap;
    logic [DATA_W-1:0] bit_ok;
    logic             word_ok;

    logic             mode_q;
    logic [LEN_W-1:0] min_q;

    rwt_sweep_ctrl #(.TAP_W(TAP_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .rd_ack    (rd_ack),
        .rd_req    (rd_req),
        .tap       (sweep_tap),
        .clear     (clear),
        .sample_en (sample_en),
        .fin       (fin),
        .busy      (busy),
        .done      (done)
    );

    assign bit_ok  = ~(rd_data ^ pattern);
    assign word_ok = &bit_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 1'b0;
            min_q  <= '0;
        end else if (clear) begin
            mode_q <= per_bit_mode && PER_BIT_EN;
            min_q  <= min_width;
        end
    end

    // whole-word window
    logic [TAP_W-1:0] agg_best_start;
    logic [LEN_W-1:0] agg_best_len;
    logic [TAP_W-1:0] agg_s, agg_e, agg_c;
    logic             agg_f;

    rwt_run_tracker #(.TAP_W(TAP_W)) u_agg_trk (
        .clk        (clk),
        .rst        (rst),
        .clear      (clear),
        .sample_en  (sample_en),
        .pass       (word_ok),
        .tap        (sweep_tap),
        .best_start (agg_best_start),
        .best_len   (agg_best_len)
    );

    rwt_window_eval #(.TAP_W(TAP_W)) u_agg_eval (
        .best_start (agg_best_start),
        .best_len   (agg_best_len),
        .min_width  (min_q),
        .w_start    (agg_s),
        .w_end      (agg_e),
        .w_center   (agg_c),
        .w_fail     (agg_f)
    );

    // per-bit windows
    logic [TAP_W-1:0] lane_c [DATA_W];
    logic             lane_f [DATA_W];

    generate
        if (PER_BIT_EN) begin : g_lanes
            for (genvar b = 0; b < DATA_W; b++) begin : g_bit
                logic [TAP_W-1:0] bs;
                logic [LEN_W-1:0] bl;
                logic [TAP_W-1:0] ls, le;
                rwt_run_tracker #(.TAP_W(TAP_W)) u_trk (
                    .clk        (clk),
                    .rst        (rst),
                    .clear      (clear),
                    .sample_en  (sample_en),
                    .pass       (bit_ok[b]),
                    .tap        (sweep_tap),
                    .best_start (bs),
                    .best_len   (bl)
                );
                rwt_window_eval #(.TAP_W(TAP_W)) u_eval (
                    .best_start (bs),
                    .best_len   (bl),
                    .min_width  (min_q),
                    .w_start    (ls),
                    .w_end      (le),
                    .w_center   (lane_c[b]),
                    .w_fail     (lane_f[b])
                );
            end
        end else begin : g_nolanes
            for (genvar b = 0; b < DATA_W; b++) begin : g_bit
                assign lane_c[b] = agg_c;
                assign lane_f[b] = agg_f;
            end
        end
    endgenerate

    // result registers, loaded once at the end of a sweep
    logic [TAP_W-1:0]        s_q, e_q, c_q;
    logic                    f_q;
    logic [DATA_W*TAP_W-1:0] bt_q;
    logic [DATA_W-1:0]       bf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q  <= '0;
            e_q  <= '0;
            c_q  <= '0;
            f_q  <= 1'b0;
            bt_q <= '0;
            bf_q <= '0;
        end else if (fin) begin
            s_q <= agg_s;
            e_q <= agg_e;
            c_q <= agg_c;
            f_q <= agg_f;
            for (int b = 0; b < DATA_W; b++) begin
                bt_q[b*TAP_W +: TAP_W] <= mode_q ? lane_c[b] : agg_c;
                bf_q[b]                <= mode_q ? lane_f[b] : agg_f;
            end
        end
    end

    assign win_start  = s_q;
    assign win_end    = e_q;
    assign win_center = c_q;
    assign fail       = f_q;
    assign bit_tap    = bt_q;
    assign bit_fail   = bf_q;
    assign tap_sel    = busy ? sweep_tap : c_q;

    // R5: a passing result centres inside its own window
    a_r5_center_inside: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> ((win_center >= win_start) && (win_center <= win_end)));

    // R6: a passing result is at least the latched minimum wide
    a_r6_width_ok: assert property (@(posedge clk) disable iff (rst)
        (done && !fail) |-> ((LEN_W'(win_end) - LEN_W'(win_start) + LEN_W'(1)) >= min_q));

    // R9: the trained tap is applied once the sweep is over
    a_r9_tap_center: assert property (@(posedge clk) disable iff (rst)
        done |-> (tap_sel == win_center));

    // R8: in word mode the per-bit flags follow the word flag
    a_r8_mirror: assert property (@(posedge clk) disable iff (rst)
        (done && !mode_q) |-> (bit_fail == {DATA_W{fail}}));

endmodule

// File: tb/read_window_trainer_tb_top.sv
module read_window_trainer_tb_top;
    localparam int DATA_W = 8;
    localparam int TAP_W  = 5;
    localparam int NTAP   = 1 << TAP_W;
    localparam logic [DATA_W-1:0] PAT = 8'hA5;

    typedef struct packed {
        logic [31:0] mask;
        logic [5:0]  minw;
        logic [4:0]  s;
        logic [4:0]  e;
        logic [4:0]  c;
        logic        f;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{32'h0000FF00, 6'd4, 5'd8,  5'd15, 5'd11, 1'b0},  // single mid window
        '{32'hFFFFFFFF, 6'd4, 5'd0,  5'd31, 5'd15, 1'b0},  // all pass
        '{32'h07F0001C, 6'd4, 5'd20, 5'd26, 5'd23, 1'b0},  // longer later run wins
        '{32'h00003C1E, 6'd4, 5'd1,  5'd4,  5'd2,  1'b0},  // tie: earlier wins
        '{32'h00000060, 6'd4, 5'd5,  5'd6,  5'd5,  1'b1},  // too narrow
        '{32'h00000000, 6'd4, 5'd0,  5'd0,  5'd0,  1'b1},  // nothing passes
        '{32'hF0000000, 6'd4, 5'd28, 5'd31, 5'd29, 1'b0},  // top edge, width == min
        '{32'h00000001, 6'd1, 5'd0,  5'd0,  5'd0,  1'b0}   // single tap at 0
    };

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    start = 1'b0;
    logic                    per_bit_mode = 1'b0;
    logic [TAP_W:0]          min_width = '0;
    logic                    rd_req;
    logic                    rd_ack = 1'b0;
    logic [DATA_W-1:0]       rd_data = '0;
    logic [TAP_W-1:0]        tap_sel;
    logic                    busy, done, fail;
    logic [TAP_W-1:0]        win_start, win_end, win_center;
    logic [DATA_W*TAP_W-1:0] bit_tap;
    logic [DATA_W-1:0]       bit_fail;

    logic [31:0] lane_mask [DATA_W];
    int reads;
    int order_err;
    int last_tap;
    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    read_window_trainer #(.DATA_W(DATA_W), .TAP_W(TAP_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .per_bit_mode(per_bit_mode),
        .min_width(min_width), .pattern(PAT), .rd_req(rd_req), .rd_ack(rd_ack),
        .rd_data(rd_data), .tap_sel(tap_sel), .busy(busy), .done(done),
        .fail(fail), .win_start(win_start), .win_end(win_end),
        .win_center(win_center), .bit_tap(bit_tap), .bit_fail(bit_fail)
    );

    // memory model: answers each request two falling edges later
    initial begin
        bit pend;
        int cnt;
        int t;
        pend = 0;
        cnt = 0;
        t = 0;
        forever begin
            @(negedge clk);
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (pend) begin
                if (cnt == 0) begin
                    for (int b = 0; b < DATA_W; b++)
                        rd_data[b] = PAT[b] ^ ~lane_mask[b][t];
                    rd_ack = 1'b1;
                    pend = 0;
                end else begin
                    cnt--;
                end
            end else if (rd_req && !rst) begin
                t = int'(tap_sel);
                if (t != last_tap + 1) order_err++;
                last_tap = t;
                reads++;
                pend = 1;
                cnt = 1;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // brute-force longest passing interval, earliest on equal length
    task automatic best_window(input logic [31:0] m, input int minw,
                               output int s, output int e, output int c, output int f);
        int bl;
        bit all;
        bl = 0; s = 0; e = 0;
        for (int a = 0; a < NTAP; a++)
            for (int z = a; z < NTAP; z++) begin
                all = 1;
                for (int k = a; k <= z; k++) if (!m[k]) all = 0;
                if (all && (z - a + 1) > bl) begin
                    bl = z - a + 1; s = a; e = z;
                end
            end
        c = (s + e) >> 1;
        f = (bl == 0 || bl < minw) ? 1 : 0;
    endtask

    task automatic sweep(input bit mode, input int minw);
        int guard;
        reads = 0;
        order_err = 0;
        last_tap = -1;
        @(negedge clk);
        per_bit_mode = mode;
        min_width = (TAP_W+1)'(minw);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        guard = 0;
        while (!done && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        chk("R2", "sweep completes", int'(done), 1);
    endtask

    logic [31:0] agg;
    int es, ee, ec, ef;

    initial begin
        for (int b = 0; b < DATA_W; b++) lane_mask[b] = '0;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", int'(busy), 0);
        chk("R1", "rd_req in reset", int'(rd_req), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "done after reset", int'(done), 0);
        chk("R1", "fail after reset", int'(fail), 0);
        chk("R1", "tap_sel after reset", int'(tap_sel), 0);
        chk("R1", "rd_req after reset", int'(rd_req), 0);

        // table walk in word mode
        for (int i = 0; i < NVEC; i++) begin
            for (int b = 0; b < DATA_W; b++) lane_mask[b] = VECS[i].mask;
            sweep(1'b0, int'(VECS[i].minw));
            chk("R2", "reads per sweep", reads, NTAP);
            chk("R2", "ascending taps", order_err, 0);
            chk("R4", "win_start", int'(win_start), int'(VECS[i].s));
            chk("R4", "win_end", int'(win_end), int'(VECS[i].e));
            chk("R5", "win_center", int'(win_center), int'(VECS[i].c));
            chk("R6", "fail", int'(fail), int'(VECS[i].f));
            chk("R9", "tap_sel at center", int'(tap_sel), int'(VECS[i].c));
            chk("R8", "bit_fail mirror", int'(bit_fail), VECS[i].f ? 255 : 0);
            for (int b = 0; b < DATA_W; b++)
                chk("R8", "bit_tap mirror", int'(bit_tap[b*TAP_W +: TAP_W]), int'(VECS[i].c));
        end

        // one corrupted bit fails the whole word (R3)
        for (int b = 0; b < DATA_W; b++) lane_mask[b] = 32'hFFFFFFFF;
        lane_mask[6] = 32'h0000FFFF;
        sweep(1'b0, 2);
        chk("R3", "single bad bit limits window end", int'(win_end), 15);
        chk("R3", "single bad bit window start", int'(win_start), 0);

        // per-bit: staggered windows, bit b passes taps b..2b+8
        agg = 32'hFFFFFFFF;
        for (int b = 0; b < DATA_W; b++) begin
            lane_mask[b] = ((32'h1 << (b + 9)) - 1) << b;
            agg = agg & lane_mask[b];
        end
        sweep(1'b1, 2);
        chk("R7", "reads in one sweep", reads, NTAP);
        best_window(agg, 2, es, ee, ec, ef);
        chk("R7", "word start", int'(win_start), es);
        chk("R7", "word end", int'(win_end), ee);
        chk("R7", "word fail", int'(fail), ef);
        for (int b = 0; b < DATA_W; b++) begin
            best_window(lane_mask[b], 2, es, ee, ec, ef);
            chk("R7", "bit tap", int'(bit_tap[b*TAP_W +: TAP_W]), ec);
            chk("R7", "bit fail", int'(bit_fail[b]), ef);
        end
        chk("R9", "tap_sel word center", int'(tap_sel), int'(win_center));

        // per-bit with one dead line
        lane_mask[3] = '0;
        sweep(1'b1, 2);
        chk("R7", "dead line flags", int'(bit_fail), 8);
        chk("R6", "empty word window fail", int'(fail), 1);
        chk("R6", "empty window start", int'(win_start), 0);
        chk("R6", "empty window end", int'(win_end), 0);
        best_window(lane_mask[5], 2, es, ee, ec, ef);
        chk("R7", "live line tap", int'(bit_tap[5*TAP_W +: TAP_W]), ec);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule